// File: doc/BRIEF.md
# Paged EEPROM access guard

This block stands between a register-bus port (driven by an SMBus slave) and a paged nonvolatile byte array, which is modelled here as an internal register array. Each bus request is either a control-register access or an array access. Array accesses are checked against a three-bit mode field and against the state of the target byte. The block then performs the read, the byte program or the page erase, or it refuses the request.

Each request gets a one-cycle-later response carrying an accept flag, so that the slave can ACK or NACK. Programs and erases occupy the array for a fixed number of cycles, and a busy counter models that time. Two further control registers are plain storage. The array is `NUM_PAGES` pages of `PAGE_BYTES` bytes starting at 8000h. With 128 pages it spans 8000h to 9FFFh. The default here is 32 pages, to keep the modelled storage small.

Top module: `eeprom_guard`

## Requirements
- R1: After reset there is no response, `busy_o` is low, all three control registers read 00h, and every array byte reads FFh (the erased value).
- R2: Every request is answered exactly one cycle later by `rsp_valid_o`. No response appears in a cycle without a request in the previous cycle.
- R3: Registers at 06h, 0Ch and 13h are always accepted, store all 8 written bits and read them back. Any other address below 8000h is rejected.
- R4: Bits [2:0] of register 13h form the mode field: bit 0 is read, bit 1 is program, bit 2 is erase. When the field is not exactly one-hot, every array access is rejected.
- R5: An array read in read mode is accepted and returns the byte. An array read in program or erase mode is rejected. Every rejected response and every write response carries data 00h.
- R6: An array write in read mode is rejected and leaves the array unchanged.
- R7: An array write in program mode is accepted only if the target byte is FFh, and it then stores the data. Otherwise it is rejected and the byte keeps its value.
- R8: An array write in erase mode is accepted and sets all `PAGE_BYTES` bytes of the addressed page to FFh. The written data is ignored, and other pages are untouched.
- R9: Program and erase requests to the top `RSV_PAGES` pages are rejected. Reads of those pages are allowed.
- R10: An accepted program raises `busy_o` for `PROG_CYCLES` cycles, and an accepted erase raises it for `PAGE_BYTES` cycles. Array accesses are rejected while busy. Register accesses are still accepted while busy.
- R11: Addresses from 8000h + `NUM_PAGES`*`PAGE_BYTES` upward are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, one cycle per access |
| we_i | input | 1 | 1 = write (program/erase/register write), 0 = read |
| addr_i | input | 16 | Register or array address |
| wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_ack_o | output | 1 | 1 = accepted (ACK), 0 = rejected (NACK) |
| rdata_o | output | 8 | Read data, 00h unless an accepted read |
| busy_o | output | 1 | Program or erase in progress |

## Verification
The response flags and read data are registered once, so they are due in the cycle after the request. `busy_o` rises in that same cycle and stays high for exactly the program or erase length. The bench drives each request on a falling edge and checks all four outputs at the next falling edge against a behavioural model that advances one step per clock. Because every idle cycle is compared as well, the length of the busy window is checked cycle by cycle, including the first access after it ends.

// File: rtl/eg_pkg.sv
package eg_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE} op_e;
  typedef enum logic [1:0] {REG_NONE, REG_CFG_A, REG_CFG_B, REG_MODE} reg_e;
  localparam logic [15:0] CFG_A_ADDR = 16'h0006;
  localparam logic [15:0] CFG_B_ADDR = 16'h000C;
  localparam logic [15:0] MODE_ADDR  = 16'h0013;
endpackage

// File: rtl/eg_check.sv
module eg_check import eg_pkg::*; #(
  parameter int NUM_PAGES  = 32,
  parameter int PAGE_BYTES = 64,
  parameter int RSV_PAGES  = 4,
  parameter int BASE       = 16'h8000,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int PG_W  = $clog2(NUM_PAGES),
  localparam int AW    = PG_W + OFF_W
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [15:0]   addr_i,
  input  logic [2:0]    mode_i,
  input  logic          busy_i,
  input  logic [7:0]    cur_i,
  output logic          in_arr_o,
  output logic          rsv_o,
  output reg_e          reg_sel_o,
  output op_e           op_o,
  output logic [AW-1:0] arr_addr_o
);
  localparam int SIZE = NUM_PAGES * PAGE_BYTES;

  logic [15:0]   off;
  logic [PG_W-1:0] page;
  logic          one_hot;

  assign off        = addr_i - 16'(BASE);
  assign in_arr_o   = (addr_i >= 16'(BASE)) && (32'(off) < 32'(SIZE));
  assign arr_addr_o = off[AW-1:0];
  assign page       = off[AW-1:OFF_W];
  assign rsv_o      = 32'(page) >= 32'(NUM_PAGES - RSV_PAGES);
  assign one_hot    = $onehot(mode_i);

  always_comb begin
    unique case (addr_i)
      CFG_A_ADDR: reg_sel_o = REG_CFG_A;
      CFG_B_ADDR: reg_sel_o = REG_CFG_B;
      MODE_ADDR:  reg_sel_o = REG_MODE;
      default:    reg_sel_o = REG_NONE;
    endcase
  end

  always_comb begin
    op_o = OP_NONE;
    if (req_i && in_arr_o && one_hot && !busy_i) begin
      if (!we_i && mode_i[0])                            op_o = OP_READ;
      else if (we_i && mode_i[1] && !rsv_o && cur_i == 8'hFF) op_o = OP_PROG;
      else if (we_i && mode_i[2] && !rsv_o)              op_o = OP_ERASE;
    end
  end
endmodule

// File: rtl/eg_store.sv
module eg_store import eg_pkg::*; #(
  parameter int NUM_PAGES   = 32,
  parameter int PAGE_BYTES  = 64,
  parameter int PROG_CYCLES = 8,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int PG_W  = $clog2(NUM_PAGES),
  localparam int AW    = PG_W + OFF_W,
  localparam int MAXC  = (PROG_CYCLES > PAGE_BYTES) ? PROG_CYCLES : PAGE_BYTES,
  localparam int CW    = $clog2(MAXC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    cur_o,
  output logic          busy_o
);
  localparam int SIZE = NUM_PAGES * PAGE_BYTES;

  logic [7:0]      mem [SIZE];
  logic [CW-1:0]   cnt;
  logic            ers_act;
  logic [PG_W-1:0] ers_page;
  logic [OFF_W-1:0] ers_off;

  initial begin
    for (int i = 0; i < SIZE; i++) mem[i] = 8'hFF;
  end

  assign cur_o   = mem[addr_i];
  assign busy_o  = cnt != '0;
  assign ers_off = OFF_W'(PAGE_BYTES - int'(cnt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt      <= '0;
      ers_act  <= 1'b0;
      ers_page <= '0;
    end else if (op_i == OP_PROG) begin
      cnt     <= CW'(PROG_CYCLES);
      ers_act <= 1'b0;
    end else if (op_i == OP_ERASE) begin
      cnt      <= CW'(PAGE_BYTES);
      ers_act  <= 1'b1;
      ers_page <= addr_i[AW-1:OFF_W];
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // erase walks the page one byte per busy cycle
  always_ff @(posedge clk_i) begin
    if (op_i == OP_PROG) mem[addr_i] <= wdata_i;
    else if (ers_act && cnt != '0) mem[{ers_page, ers_off}] <= 8'hFF;
  end

  a_r7_prog_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_PROG |=> mem[$past(addr_i)] == $past(wdata_i));
  a_r10_erase_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_ERASE |=> busy_o);
  a_r10_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> op_i == OP_NONE || op_i == OP_READ ? op_i == OP_NONE : 1'b0);
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard import eg_pkg::*; #(
  parameter int NUM_PAGES   = 32,
  parameter int PAGE_BYTES  = 64,
  parameter int RSV_PAGES   = 4,
  parameter int PROG_CYCLES = 8,
  parameter int BASE        = 16'h8000,
  localparam int AW = $clog2(NUM_PAGES) + $clog2(PAGE_BYTES)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  output logic        rsp_valid_o,
  output logic        rsp_ack_o,
  output logic [7:0]  rdata_o,
  output logic        busy_o
);
  logic [7:0]    cfg_a, cfg_b, mode_q;
  logic          in_arr, rsv, busy;
  reg_e          reg_sel;
  op_e           op;
  logic [AW-1:0] arr_addr;
  logic [7:0]    cur;
  logic          reg_hit;

  eg_check #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES),
             .RSV_PAGES(RSV_PAGES), .BASE(BASE)) u_check (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .mode_i(mode_q[2:0]),
    .busy_i(busy), .cur_i(cur), .in_arr_o(in_arr), .rsv_o(rsv),
    .reg_sel_o(reg_sel), .op_o(op), .arr_addr_o(arr_addr));

  eg_store #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES),
             .PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .addr_i(arr_addr),
    .wdata_i(wdata_i), .cur_o(cur), .busy_o(busy));

  assign busy_o  = busy;
  assign reg_hit = req_i && reg_sel != REG_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_a       <= '0;
      cfg_b       <= '0;
      mode_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_ack_o   <= 1'b0;
      rdata_o     <= '0;
    end else begin
      rsp_valid_o <= req_i;
      rsp_ack_o   <= reg_hit || op != OP_NONE;
      rdata_o     <= '0;
      if (reg_hit && we_i) begin
        case (reg_sel)
          REG_CFG_A: cfg_a  <= wdata_i;
          REG_CFG_B: cfg_b  <= wdata_i;
          REG_MODE:  mode_q <= wdata_i;
          default: ;
        endcase
      end else if (reg_hit) begin
        case (reg_sel)
          REG_CFG_A: rdata_o <= cfg_a;
          REG_CFG_B: rdata_o <= cfg_b;
          REG_MODE:  rdata_o <= mode_q;
          default: ;
        endcase
      end else if (op == OP_READ) begin
        rdata_o <= cur;
      end
    end
  end

  a_r2_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  a_r4_mode_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && in_arr && !$onehot(mode_q[2:0]) |=> !rsp_ack_o);
  a_r9_rsv_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && in_arr && rsv |=> !rsp_ack_o);
  a_r10_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && in_arr && busy_o |=> !rsp_ack_o);
  a_r5_nack_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ack_o |-> rdata_o == 8'h00);
endmodule

// File: tb/eeprom_guard_test.sv
module eeprom_guard_test;
  localparam int NP = 32, PB = 64, RP = 4, PC = 8;
  localparam int BASE = 16'h8000, SIZE = NP * PB;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic rsp_valid, rsp_ack, busy;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  int m_mem [SIZE];
  int m_a = 0, m_b = 0, m_mode = 0, m_cnt = 0;
  logic e_valid = 0, e_ack = 0;
  int e_rd = 0;

  always #2 clk = ~clk;

  eeprom_guard #(.NUM_PAGES(NP), .PAGE_BYTES(PB), .RSV_PAGES(RP),
                 .PROG_CYCLES(PC), .BASE(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rsp_valid_o(rsp_valid), .rsp_ack_o(rsp_ack),
    .rdata_o(rdata), .busy_o(busy));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "valid", rsp_valid, e_valid);
    chk(tag, "ack", rsp_ack, e_ack);
    chk(tag, "rdata", rdata, e_rd);
    chk(tag, "busy", busy, m_cnt != 0);
  endtask

  // one request, modelled and checked one cycle later
  task automatic acc(bit w, int a, int d, string tag);
    bit in_arr, rsv, oh, bsy;
    int off;
    in_arr = a >= BASE && a < BASE + SIZE;
    off = a - BASE;
    rsv = in_arr && (off / PB) >= NP - RP;
    oh = (m_mode & 7) inside {1, 2, 4};
    bsy = m_cnt != 0;
    e_valid = 1; e_ack = 0; e_rd = 0;
    if (m_cnt > 0) m_cnt--;
    if (a == 6 || a == 12 || a == 'h13) begin
      e_ack = 1;
      if (w) begin
        if (a == 6) m_a = d; else if (a == 12) m_b = d; else m_mode = d;
      end else e_rd = (a == 6) ? m_a : (a == 12) ? m_b : m_mode;
    end else if (in_arr && oh && !bsy) begin
      if (!w && m_mode[0]) begin e_ack = 1; e_rd = m_mem[off]; end
      else if (w && m_mode[1] && !rsv && m_mem[off] == 'hFF) begin
        e_ack = 1; m_mem[off] = d; m_cnt = PC;
      end else if (w && m_mode[2] && !rsv) begin
        e_ack = 1; m_cnt = PB;
        for (int i = 0; i < PB; i++) m_mem[(off / PB) * PB + i] = 'hFF;
      end
    end
    req = 1; we = w; addr = 16'(a); wdata = 8'(d);
    @(negedge clk);
    req = 0;
    compare(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) begin
      e_valid = 0; e_ack = 0; e_rd = 0;
      if (m_cnt > 0) m_cnt--;
      @(negedge clk);
      compare(tag);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < SIZE; i++) m_mem[i] = 'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset");
    acc(0, 6, 0, "R1 reg06");
    acc(0, 'h13, 0, "R1 mode");
    // R4: mode not one-hot
    acc(0, BASE, 0, "R4 zero mode");
    acc(1, 'h13, 3, "R3 mode wr");
    acc(0, BASE, 0, "R4 two bits");
    acc(1, 'h13, 7, "R3 mode wr");
    acc(1, BASE + 1, 'h12, "R4 three bits");
    // R3 storage registers
    acc(1, 6, 'hA7, "R3 wr06");
    acc(1, 12, 'h3C, "R3 wr0C");
    acc(0, 6, 0, "R3 rd06");
    acc(0, 12, 0, "R3 rd0C");
    acc(0, 'h13, 0, "R3 rd13");
    acc(0, 0, 0, "R3 other reg");
    acc(1, 'h70, 5, "R3 other reg wr");
    // read mode
    acc(1, 'h13, 1, "R3 mode wr");
    acc(0, BASE, 0, "R1 erased FF");
    acc(1, BASE, 'h00, "R6 write in read mode");
    acc(0, BASE, 0, "R6 unchanged");
    acc(0, BASE + SIZE, 0, "R11 beyond window");
    acc(0, 'h9FFF, 0, "R11 top of map");
    // program mode
    acc(1, 'h13, 2, "R3 mode wr");
    acc(0, BASE + 5, 0, "R5 read in program mode");
    acc(1, BASE + 5, 'hA5, "R7 program");
    acc(1, BASE + 6, 'h00, "R10 array while busy");
    acc(0, 6, 0, "R10 reg while busy");
    idle(PC, "R10 program busy");
    acc(1, BASE + 5, 'h5A, "R7 reprogram rejected");
    idle(PC, "R10 idle");
    acc(1, BASE + 6, 'h00, "R7 program zero");
    idle(PC, "R10 program busy");
    acc(1, BASE + PB, 'h11, "R7 program page 1");
    idle(PC, "R10 program busy");
    acc(1, BASE + (NP - 1) * PB + 3, 'h22, "R9 program reserved");
    acc(1, BASE + SIZE, 'h22, "R11 program beyond");
    // read back
    acc(1, 'h13, 1, "R3 mode wr");
    acc(0, BASE + 5, 0, "R7 read A5");
    acc(0, BASE + 6, 0, "R7 read 00");
    acc(0, BASE + (NP - 1) * PB + 3, 0, "R9 reserved read");
    // erase mode
    acc(1, 'h13, 4, "R3 mode wr");
    acc(0, BASE, 0, "R5 read in erase mode");
    acc(1, BASE + (NP - RP) * PB, 0, "R9 erase reserved");
    acc(1, BASE + 'h10, 'h00, "R8 erase page 0");
    acc(1, BASE + PB, 0, "R10 erase while busy");
    acc(1, 'h13, 4, "R10 reg while busy");
    idle(PB, "R10 erase busy");
    acc(1, 'h13, 1, "R3 mode wr");
    acc(0, BASE + 5, 0, "R8 erased byte 5");
    acc(0, BASE + 6, 0, "R8 erased byte 6");
    acc(0, BASE + PB, 0, "R8 other page kept");
    acc(1, 'h13, 2, "R3 mode wr");
    acc(1, BASE + 5, 'h77, "R8 program after erase");
    idle(PC, "R10 program busy");
    acc(1, 'h13, 1, "R3 mode wr");
    acc(0, BASE + 5, 0, "R8 read 77");
    idle(2, "R2 no request");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule